// File: doc/BRIEF.md
# Single-Frame Network Buffer Peripheral

This peripheral sits between a processor's register bus and a byte-wide frame path. It keeps one received frame and one outgoing frame, each up to `FRAME_MAX` bytes, and software moves every payload byte through a small register window one access at a time. An incoming frame arrives on a valid/ready byte stream with an end-of-frame marker. A frame that software has fully written leaves on a second valid/ready stream with a last flag.

A busy flag and a 32-bit interrupt-control word decide when a new frame may enter. Receiving or sending a frame sets busy and a done cause. Software clears the causes one write at a time, and busy falls once no cause remains. A test bit in the control word triggers a soft reset of all buffer state, sets itself, and clears again when software reads it. The level interrupt output is high while any control bit is set.

Top module: `nic_frame_buf`

## Requirements
- R1: Only address bits [5:0] are decoded (so 0x48 aliases 0x08). Offset 0x00 reads 0x4E494342 and offset 0x04 reads 0x55463031. Offset 0x18 (interrupt info) and offset 0x20 (TX data) always read 0.
- R2: After reset, busy (0x08) reads 1, RX count (0x0C) and TX count (0x10) read 0, interrupt control (0x14) reads 0, irq is low and in_ready is low.
- R3: in_ready is high within a frame and, between frames, only when busy is 0 and the RX count is below FRAME_MAX. When the beat carrying in_last is accepted, the RX count becomes the frame length, the read position returns to the first byte, busy becomes 1 and control bit 1 (RX-done) is set.
- R4: For a frame longer than FRAME_MAX bytes, all beats are consumed, only the first FRAME_MAX bytes are kept, and the RX count becomes FRAME_MAX.
- R5: While the RX count is nonzero, each read of 0x1C returns the next stored byte in arrival order and decrements the count. While the count is zero, a read of 0x1C returns 0 and the count stays 0.
- R6: A write to 0x10 loads the TX count with the written value when it is at most FRAME_MAX, and with 0 otherwise. The write also restarts the TX fill position at the first byte.
- R7: A write to 0x20 stores bits [7:0] as the next TX byte. When the number of stored bytes reaches the TX count, the frame leaves on the egress stream in order, with out_last set on the final byte and out_data held while out_ready is low. At the same time the TX count returns to 0, control bit 0 (TX-done) is set and busy becomes 1. Writes to 0x20 while the TX count is 0 are ignored.
- R8: Writes to 0x20 while the egress stream still holds an unfinished frame are ignored and do not alter that frame.
- R9: A write to 0x14 acts on exactly one cause. If bit 0 is set, it clears TX-done. Otherwise, if bit 1 is set, it clears RX-done. Otherwise, if bit 31 is set, it clears all buffer state (both counts, the positions, and any frame in progress on either stream) and leaves interrupt control at 0x80000000. After such a write, busy is 1 exactly when interrupt control is nonzero.
- R10: A read of 0x14 returns the current control word and clears bit 31 in the same access.
- R11: irq is high exactly when interrupt control is nonzero.
- R12: Writes to 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address (bits [5:0] decoded) |
| reg_rd | input | 1 | Read strobe; read side effects take place at the clock edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, valid in the strobe cycle |
| in_valid | input | 1 | Ingress byte valid |
| in_data | input | 8 | Ingress byte |
| in_last | input | 1 | Ingress end of frame |
| in_ready | output | 1 | Ingress ready |
| out_valid | output | 1 | Egress byte valid |
| out_data | output | 8 | Egress byte |
| out_last | output | 1 | Egress final byte |
| out_ready | input | 1 | Egress ready |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach is a receive buffer that is full but no longer busy. In that state in_ready must stay low even though software has acknowledged the RX-done cause. The bench gets there by delivering a frame of exactly FRAME_MAX bytes and then clearing RX-done without reading any data. It then pops one byte and expects ready to return. A second awkward situation is a TX-data write that arrives while the egress stream is stalled mid-frame. The bench holds out_ready low after a frame completes, rearms the TX count and writes a byte, then checks that the first byte drained is still the original one.

// File: rtl/nic_fb_pkg.sv
package nic_fb_pkg;
  localparam logic [5:0] OFS_ID0    = 6'h00;
  localparam logic [5:0] OFS_ID1    = 6'h04;
  localparam logic [5:0] OFS_BUSY   = 6'h08;
  localparam logic [5:0] OFS_RXCNT  = 6'h0C;
  localparam logic [5:0] OFS_TXCNT  = 6'h10;
  localparam logic [5:0] OFS_INTCTL = 6'h14;
  localparam logic [5:0] OFS_INFO   = 6'h18;
  localparam logic [5:0] OFS_RXDAT  = 6'h1C;
  localparam logic [5:0] OFS_TXDAT  = 6'h20;

  localparam logic [31:0] SIG_HI = 32'h4E49_4342;
  localparam logic [31:0] SIG_LO = 32'h5546_3031;

  localparam int BIT_TXDONE = 0;
  localparam int BIT_RXDONE = 1;
  localparam int BIT_TEST   = 31;
endpackage

// File: rtl/nic_fb_rx.sv
module nic_fb_rx #(
  parameter int FRAME_MAX = 1514,
  parameter int CNT_W     = $clog2(FRAME_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             busy,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  input  logic             pop,
  output logic [CNT_W-1:0] rx_cnt,
  output logic [7:0]       rx_byte,
  output logic             done_evt,
  output logic             in_frame
);
  localparam logic [CNT_W-1:0] MAXV = CNT_W'(FRAME_MAX);

  logic [7:0]       mem [FRAME_MAX];
  logic [CNT_W-1:0] wr_q, wr_n, rd_q, rd_n, cnt_q, cnt_n;
  logic             frame_q, frame_n;
  logic             accept, room;

  assign in_ready = frame_q || (!busy && (cnt_q < MAXV));
  assign accept   = in_valid && in_ready;
  assign room     = wr_q < MAXV;
  assign done_evt = accept && in_last && !soft_clr;
  assign rx_cnt   = cnt_q;
  assign in_frame = frame_q;
  assign rx_byte  = (cnt_q != '0) ? mem[rd_q] : 8'h00;

  always_comb begin
    wr_n    = wr_q;
    rd_n    = rd_q;
    cnt_n   = cnt_q;
    frame_n = frame_q;
    if (soft_clr) begin
      wr_n    = '0;
      rd_n    = '0;
      cnt_n   = '0;
      frame_n = 1'b0;
    end else begin
      if (pop && (cnt_q != '0)) begin
        rd_n  = rd_q + 1'b1;
        cnt_n = cnt_q - 1'b1;
      end
      if (accept) begin
        if (in_last) begin
          frame_n = 1'b0;
          wr_n    = '0;
          rd_n    = '0;
          cnt_n   = room ? (wr_q + 1'b1) : MAXV;
        end else begin
          frame_n = 1'b1;
          if (room) wr_n = wr_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      frame_q <= 1'b0;
    end else begin
      wr_q    <= wr_n;
      rd_q    <= rd_n;
      cnt_q   <= cnt_n;
      frame_q <= frame_n;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && room && !soft_clr) mem[wr_q] <= in_data;
  end
endmodule

// File: rtl/nic_fb_tx.sv
module nic_fb_tx #(
  parameter int FRAME_MAX = 1514,
  parameter int CNT_W     = $clog2(FRAME_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             cnt_wr,
  input  logic             data_wr,
  input  logic [31:0]      wdata,
  output logic [CNT_W-1:0] tx_cnt,
  output logic             done_evt,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  input  logic             out_ready
);
  localparam logic [CNT_W-1:0] MAXV = CNT_W'(FRAME_MAX);

  logic [7:0]       mem [FRAME_MAX];
  logic [CNT_W-1:0] cnt_q, cnt_n, wp_q, wp_n, dp_q, dp_n, dl_q, dl_n;
  logic             drain_q, drain_n;
  logic             store, fill_end;

  assign store     = data_wr && !drain_q && (cnt_q != '0) && !soft_clr;
  assign fill_end  = store && ((wp_q + 1'b1) == cnt_q);
  assign done_evt  = fill_end;
  assign tx_cnt    = cnt_q;
  assign out_valid = drain_q;
  assign out_data  = mem[dp_q];
  assign out_last  = drain_q && (dp_q == (dl_q - 1'b1));

  always_comb begin
    cnt_n   = cnt_q;
    wp_n    = wp_q;
    dp_n    = dp_q;
    dl_n    = dl_q;
    drain_n = drain_q;
    if (soft_clr) begin
      cnt_n   = '0;
      wp_n    = '0;
      dp_n    = '0;
      drain_n = 1'b0;
    end else begin
      if (drain_q && out_ready) begin
        if (out_last) begin
          drain_n = 1'b0;
          dp_n    = '0;
        end else begin
          dp_n = dp_q + 1'b1;
        end
      end
      if (cnt_wr) begin
        cnt_n = (wdata <= 32'(FRAME_MAX)) ? wdata[CNT_W-1:0] : '0;
        wp_n  = '0;
      end else if (fill_end) begin
        drain_n = 1'b1;
        dp_n    = '0;
        dl_n    = cnt_q;
        cnt_n   = '0;
        wp_n    = '0;
      end else if (store) begin
        wp_n = wp_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      wp_q    <= '0;
      dp_q    <= '0;
      dl_q    <= '0;
      drain_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      wp_q    <= wp_n;
      dp_q    <= dp_n;
      dl_q    <= dl_n;
      drain_q <= drain_n;
    end
  end

  always_ff @(posedge clk) begin
    if (store && (wp_q < MAXV)) mem[wp_q] <= wdata[7:0];
  end
endmodule

// File: rtl/nic_fb_ctrl.sv
module nic_fb_ctrl
  import nic_fb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ic_wr,
  input  logic        ic_rd,
  input  logic [31:0] wdata,
  input  logic        rx_evt,
  input  logic        tx_evt,
  output logic [31:0] intctl,
  output logic        busy,
  output logic        soft_clr
);
  logic [31:0] ic_q, ic_n;
  logic        busy_q, busy_n;

  assign soft_clr = ic_wr && wdata[BIT_TEST] && !wdata[BIT_TXDONE] && !wdata[BIT_RXDONE];
  assign intctl   = ic_q;
  assign busy     = busy_q;

  always_comb begin
    ic_n   = ic_q;
    busy_n = busy_q;
    if (ic_rd) ic_n[BIT_TEST] = 1'b0;
    if (ic_wr) begin
      if (wdata[BIT_TXDONE])      ic_n[BIT_TXDONE] = 1'b0;
      else if (wdata[BIT_RXDONE]) ic_n[BIT_RXDONE] = 1'b0;
      else if (wdata[BIT_TEST])   ic_n = 32'h8000_0000;
      busy_n = |ic_n;
    end
    if (rx_evt) begin
      ic_n[BIT_RXDONE] = 1'b1;
      busy_n           = 1'b1;
    end
    if (tx_evt) begin
      ic_n[BIT_TXDONE] = 1'b1;
      busy_n           = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ic_q   <= '0;
      busy_q <= 1'b1;
    end else begin
      ic_q   <= ic_n;
      busy_q <= busy_n;
    end
  end
endmodule

// File: rtl/nic_frame_buf.sv
module nic_frame_buf
  import nic_fb_pkg::*;
#(
  parameter int FRAME_MAX = 1514,
  parameter int CNT_W     = $clog2(FRAME_MAX + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  input  logic        out_ready,
  output logic        irq
);
  logic [5:0]       ofs;
  logic [31:0]      intctl;
  logic             busy, soft_clr, rx_evt, tx_evt, rx_in_frame;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic [7:0]       rx_byte;

  assign ofs = reg_addr[5:0];
  assign irq = |intctl;

  nic_fb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ic_wr(reg_wr && (ofs == OFS_INTCTL)),
    .ic_rd(reg_rd && (ofs == OFS_INTCTL)),
    .wdata(reg_wdata), .rx_evt(rx_evt), .tx_evt(tx_evt),
    .intctl(intctl), .busy(busy), .soft_clr(soft_clr)
  );

  nic_fb_rx #(.FRAME_MAX(FRAME_MAX), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .busy(busy),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .pop(reg_rd && (ofs == OFS_RXDAT)),
    .rx_cnt(rx_cnt), .rx_byte(rx_byte), .done_evt(rx_evt), .in_frame(rx_in_frame)
  );

  nic_fb_tx #(.FRAME_MAX(FRAME_MAX), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .cnt_wr(reg_wr && (ofs == OFS_TXCNT)),
    .data_wr(reg_wr && (ofs == OFS_TXDAT)),
    .wdata(reg_wdata), .tx_cnt(tx_cnt), .done_evt(tx_evt),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );

  always_comb begin
    unique case (ofs)
      OFS_ID0:    reg_rdata = SIG_HI;
      OFS_ID1:    reg_rdata = SIG_LO;
      OFS_BUSY:   reg_rdata = {31'd0, busy};
      OFS_RXCNT:  reg_rdata = 32'(rx_cnt);
      OFS_TXCNT:  reg_rdata = 32'(tx_cnt);
      OFS_INTCTL: reg_rdata = intctl;
      OFS_RXDAT:  reg_rdata = {24'd0, rx_byte};
      default:    reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/nic_frame_buf_chk.sv
module nic_frame_buf_chk
  import nic_fb_pkg::*;
#(
  parameter int FRAME_MAX = 1514,
  parameter int CNT_W     = $clog2(FRAME_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       reg_addr,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic             in_valid,
  input logic             in_last,
  input logic             in_ready,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic             out_ready,
  input logic             busy,
  input logic             in_frame,
  input logic             soft_clr,
  input logic [31:0]      intctl,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [CNT_W-1:0] tx_cnt
);
  logic rx_end;
  assign rx_end = in_valid && in_ready && in_last;

  AST_RX_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CNT_W'(FRAME_MAX)); // R4
  AST_TX_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CNT_W'(FRAME_MAX)); // R6
  AST_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_frame) |-> !in_ready); // R3
  AST_RX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && !soft_clr) |=> (busy && intctl[BIT_RXDONE] && (rx_cnt != '0))); // R3
  AST_RX_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr[5:0] == OFS_RXDAT) && (rx_cnt != '0) && !rx_end && !soft_clr)
      |=> (rx_cnt == $past(rx_cnt) - 1'b1)); // R5
  AST_TEST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && (reg_addr[5:0] == OFS_INTCTL)) |=> !intctl[BIT_TEST]); // R10
  AST_EGRESS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !soft_clr) |=> (out_valid && $stable(out_data))); // R7
endmodule

bind nic_frame_buf nic_frame_buf_chk #(.FRAME_MAX(FRAME_MAX), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
  .busy(busy), .in_frame(rx_in_frame), .soft_clr(soft_clr), .intctl(intctl),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt)
);

// File: tb/nic_frame_buf_test.sv
`timescale 1ns/1ps
module nic_frame_buf_test;
  localparam int FMAX = 1514;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_rd, reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        in_valid, in_last, in_ready;
  logic [7:0]  in_data;
  logic        out_valid, out_last, out_ready;
  logic [7:0]  out_data;
  logic        irq;

  int nchk = 0;
  int nbad = 0;

  always #10 clk = ~clk;

  nic_frame_buf uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 13) + seed);
  endfunction

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #5 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic send_frame(input int len, input int seed);
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_data = pat(i, seed); in_last = (i == len - 1);
      #5 if (i == 0) chk("R3 ready at frame start", {31'd0, in_ready}, 32'd1);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // drain n bytes from egress; starts at a negedge
  task automatic drain(input int n, input logic [7:0] e0, input logic [7:0] e1,
                       input logic [7:0] e2, input string tag);
    logic [7:0] ex [3];
    ex[0] = e0; ex[1] = e1; ex[2] = e2;
    out_ready = 1'b1;
    for (int k = 0; k < n; k++) begin
      #5;
      chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
      chk({tag, " data"}, {24'd0, out_data}, {24'd0, ex[k]});
      chk({tag, " last"}, {31'd0, out_last}, {31'd0, (k == n - 1)});
      @(negedge clk);
    end
    #5 chk({tag, " idle after"}, {31'd0, out_valid}, 32'd0);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R2 irq", {31'd0, irq}, 32'd0);
    chk("R2 in_ready", {31'd0, in_ready}, 32'd0);
    rd_chk(8'h08, 32'd1, "R2 busy");
    rd_chk(8'h0C, 32'd0, "R2 rx count");
    rd_chk(8'h10, 32'd0, "R2 tx count");
    rd_chk(8'h14, 32'd0, "R2 intctl");
  endtask

  task automatic t_ident;
    rd_chk(8'h00, 32'h4E494342, "R1 id0");
    rd_chk(8'h04, 32'h55463031, "R1 id1");
    rd_chk(8'h18, 32'd0, "R1 info");
    rd_chk(8'h20, 32'd0, "R1 tx data reads 0");
    rd_chk(8'h48, 32'd1, "R1 alias busy");
    rd_chk(8'hC4, 32'h55463031, "R1 alias id1");
  endtask

  task automatic t_rx_basic;
    wr(8'h14, 32'd0);
    rd_chk(8'h08, 32'd0, "R9 busy after zero write");
    send_frame(5, 3);
    #5;
    chk("R11 irq on rx", {31'd0, irq}, 32'd1);
    chk("R3 ready low after frame", {31'd0, in_ready}, 32'd0);
    rd_chk(8'h0C, 32'd5, "R3 rx count");
    rd_chk(8'h14, 32'd2, "R3 rx done bit");
    rd_chk(8'h08, 32'd1, "R3 busy");
    for (int i = 0; i < 5; i++) rd_chk(8'h1C, {24'd0, pat(i, 3)}, "R5 rx byte");
    rd_chk(8'h0C, 32'd0, "R5 count drained");
    rd_chk(8'h1C, 32'd0, "R5 empty read");
    rd_chk(8'h0C, 32'd0, "R5 count stays 0");
    wr(8'h14, 32'd2);
    rd_chk(8'h14, 32'd0, "R9 rx done cleared");
    rd_chk(8'h08, 32'd0, "R9 busy falls");
    #1 chk("R11 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_rx_trunc;
    send_frame(FMAX + 6, 9);
    rd_chk(8'h0C, FMAX, "R4 truncated count");
    for (int i = 0; i < FMAX; i++) rd_chk(8'h1C, {24'd0, pat(i, 9)}, "R4 kept byte");
    rd_chk(8'h1C, 32'd0, "R4 read past end");
    wr(8'h14, 32'd2);
    send_frame(FMAX, 5);
    wr(8'h14, 32'd2);
    rd_chk(8'h08, 32'd0, "R3 busy clear with full buffer");
    #1 chk("R3 ready low while full", {31'd0, in_ready}, 32'd0);
    rd_chk(8'h1C, {24'd0, pat(0, 5)}, "R5 first byte of full frame");
    #1 chk("R3 ready back after pop", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_tx;
    wr(8'h10, 32'd2000);
    rd_chk(8'h10, 32'd0, "R6 oversize count");
    wr(8'h10, FMAX);
    rd_chk(8'h10, FMAX, "R6 max count");
    wr(8'h10, 32'd0);
    wr(8'h20, 32'hAA);
    rd_chk(8'h14, 32'd0, "R7 write with zero count ignored");
    #1 chk("R7 no egress", {31'd0, out_valid}, 32'd0);
    wr(8'h10, 32'd3);
    wr(8'h20, 32'h1A1);
    wr(8'h20, 32'h1B2);
    wr(8'h20, 32'h1C3);
    rd_chk(8'h10, 32'd0, "R7 tx count cleared");
    rd_chk(8'h14, 32'd1, "R7 tx done bit");
    rd_chk(8'h08, 32'd1, "R7 busy");
    drain(3, 8'hA1, 8'hB2, 8'hC3, "R7 egress");
    wr(8'h10, 32'd3);
    wr(8'h20, 32'h11);
    wr(8'h10, 32'd2);
    wr(8'h20, 32'h22);
    wr(8'h20, 32'h33);
    drain(2, 8'h22, 8'h33, 8'h00, "R6 pointer restart");
    wr(8'h14, 32'd1);
    rd_chk(8'h14, 32'd0, "R9 tx done cleared");
  endtask

  task automatic t_tx_drain;
    wr(8'h10, 32'd3);
    wr(8'h20, 32'h41);
    wr(8'h20, 32'h42);
    wr(8'h20, 32'h43);
    wr(8'h10, 32'd2);
    wr(8'h20, 32'hEE);
    wr(8'h20, 32'hEF);
    drain(3, 8'h41, 8'h42, 8'h43, "R8 frame intact");
    rd_chk(8'h10, 32'd2, "R8 count kept");
    wr(8'h20, 32'h51);
    wr(8'h20, 32'h52);
    drain(2, 8'h51, 8'h52, 8'h00, "R8 later frame");
    wr(8'h14, 32'd1);
  endtask

  task automatic t_prio;
    rd_chk(8'h08, 32'd0, "R9 idle busy");
    send_frame(4, 1);
    wr(8'h10, 32'd1);
    wr(8'h20, 32'h77);
    drain(1, 8'h77, 8'h00, 8'h00, "R7 one byte frame");
    rd_chk(8'h14, 32'd3, "R9 both causes");
    wr(8'h14, 32'h8000_0003);
    rd_chk(8'h14, 32'd2, "R9 only tx cleared");
    rd_chk(8'h08, 32'd1, "R9 busy held");
    wr(8'h14, 32'h8000_0002);
    rd_chk(8'h14, 32'd0, "R9 rx cleared");
    rd_chk(8'h0C, 32'd4, "R9 no soft reset");
    rd_chk(8'h08, 32'd0, "R9 busy low");
    wr(8'h10, 32'd9);
    wr(8'h14, 32'h8000_0000);
    #1 chk("R11 irq on test bit", {31'd0, irq}, 32'd1);
    rd_chk(8'h0C, 32'd0, "R9 soft reset rx count");
    rd_chk(8'h10, 32'd0, "R9 soft reset tx count");
    rd_chk(8'h08, 32'd1, "R9 busy with test bit");
    rd_chk(8'h14, 32'h8000_0000, "R10 test bit read");
    rd_chk(8'h14, 32'd0, "R10 cleared by read");
    #1 chk("R11 irq low", {31'd0, irq}, 32'd0);
    wr(8'h14, 32'd0);
    rd_chk(8'h08, 32'd0, "R9 zero write busy");
  endtask

  task automatic t_ro;
    wr(8'h08, 32'd1);
    wr(8'h0C, 32'd5);
    wr(8'h00, 32'd0);
    wr(8'h04, 32'd0);
    wr(8'h18, 32'hFF);
    wr(8'h1C, 32'h55);
    rd_chk(8'h08, 32'd0, "R12 busy");
    rd_chk(8'h0C, 32'd0, "R12 rx count");
    rd_chk(8'h00, 32'h4E494342, "R12 id0");
    rd_chk(8'h04, 32'h55463031, "R12 id1");
    rd_chk(8'h18, 32'd0, "R12 info");
    rd_chk(8'h1C, 32'd0, "R12 rx data");
    rd_chk(8'h14, 32'd0, "R12 intctl");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ident;
    t_rx_basic;
    t_rx_trunc;
    t_tx;
    t_tx_drain;
    t_prio;
    t_ro;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule